// File: doc/BRIEF.md
# Indirect Interrupt-Routing Register Window

This block holds the programmable state of an interrupt router and makes it reachable through two 32-bit locations. Software first writes a register number into a select location. Accesses to a separate data location then read or write the register that the select value points at.

Behind the window sit four kinds of register:
- a 4-bit unit identifier;
- an arbitration word;
- a read-only version word, built from the number of routing entries;
- a table of 64-bit routing entries, reached one 32-bit half at a time.

The whole table is exported in parallel to the delivery and service logic. That logic also receives the per-entry mask and trigger-type bits, already decoded from their field positions.

Accesses use a one-cycle strobe with a write flag. A read answers with registered data one cycle after its strobe. An error flag is raised in the same cycle for any access that hits no register.

Top module: `intc_regwin`

## Requirements
- R1: After reset the select word, the identifier and the arbitration word are zero. Every table entry reads 64'h0000_0000_0001_0000, meaning only the mask bit (bit 16) is set.
- R2: Only address bits 7:0 are decoded. Offset 0x00 is the select location: a write stores all 32 bits, and a read returns them unchanged. Higher address bits are ignored, so 0x100 aliases 0x00.
- R3: An access at any offset other than 0x00 or 0x10 raises the error flag. A read there returns zero, and a write there changes no state.
- R4: With select value 0, the data location is the identifier. A write takes the identifier from write-data bits 27:24. A read returns it in bits 27:24 with all other bits zero. The identifier is also driven on `unit_id`.
- R5: With select value 1, the data location reads as (NUM_ENT-1) in bits 23:16 and 0x11 in bits 7:0, with all other bits zero. For 24 entries this is 32'h0017_0011. Writes to it change nothing and raise no error.
- R6: With select value 2, a write stores all 32 bits into the arbitration word, which is driven on `arb_word`. A read returns the identifier in bits 27:24 and zero elsewhere.
- R7: A select value s of 0x10 or more addresses table entry (s-0x10)>>1. An even s reaches bits 31:0 of that entry and an odd s reaches bits 63:32. A write changes only that half, and the new value appears on `tbl_flat` (entry k at bits 64k+63:64k) the cycle after the strobe.
- R8: A select value from 3 to 0x0F, or one whose entry index is NUM_ENT or more, is an error. A data-location read then returns zero with the error flag set, and a write is dropped with the error flag set.
- R9: `rd_valid` is high exactly in the cycle after a read strobe, and `rd_data` and `acc_err` belong to that read. Write strobes never raise `rd_valid`.
- R10: For every entry k, `ent_mask[k]` equals bit 16 of the entry and `ent_level[k]` equals bit 15 (1 = level-triggered).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read, qualified by acc_valid |
| acc_addr | input | ADDR_W | Byte offset; bits 7:0 decoded |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| acc_err | output | 1 | Error for the access strobed one cycle earlier |
| unit_id | output | 4 | Current identifier |
| arb_word | output | 32 | Current arbitration word |
| tbl_flat | output | NUM_ENT*64 | All routing entries, entry k in bits 64k+63:64k |
| ent_mask | output | NUM_ENT | Per-entry mask bit |
| ent_level | output | NUM_ENT | Per-entry level-trigger bit |

## Verification
The assertions take for granted that `acc_valid` is a clean one-cycle strobe. They also assume that `acc_write` and `acc_addr` are settled while it is high, and that no register changes except through a write strobe. The bench drives each access for exactly one cycle and always follows it with an idle cycle, so every response lands in a known cycle. It also never strobes during reset. The bench compares the exported table, the identifier, the arbitration word and the decoded field bits against its own model on every access. It covers both table halves, the first and last entries, and select values just outside the legal range.

// File: rtl/intc_regwin_pkg.sv
package intc_regwin_pkg;
  localparam int WORD_W = 32;
  localparam int ENT_W  = 2 * WORD_W;
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [31:0] SEL_TBL_BASE = 32'h10;
  localparam logic [7:0] VER_CODE = 8'h11;
  localparam int MASK_BIT  = 16;
  localparam int LEVEL_BIT = 15;

  typedef enum logic [2:0] {
    TGT_ID  = 3'd0,
    TGT_VER = 3'd1,
    TGT_ARB = 3'd2,
    TGT_TBL = 3'd3,
    TGT_BAD = 3'd4
  } tgt_e;
endpackage

// File: rtl/intc_regwin_decode.sv
module intc_regwin_decode
  import intc_regwin_pkg::*;
#(
  parameter int NUM_ENT = 24,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic [WORD_W-1:0] sel,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  idx,
  output logic              hi
);
  localparam logic [31:0] SEL_LIMIT = SEL_TBL_BASE + 32'(2 * NUM_ENT);
  logic [31:0] rel;

  always_comb begin
    rel = sel - SEL_TBL_BASE;
    idx = rel[IDX_W:1];
    hi  = sel[0];
    if (sel == 32'd0)                              tgt = TGT_ID;
    else if (sel == 32'd1)                         tgt = TGT_VER;
    else if (sel == 32'd2)                         tgt = TGT_ARB;
    else if (sel >= SEL_TBL_BASE && sel < SEL_LIMIT) tgt = TGT_TBL;
    else                                           tgt = TGT_BAD;
  end
endmodule

// File: rtl/intc_regwin_bank.sv
module intc_regwin_bank
  import intc_regwin_pkg::*;
#(
  parameter int NUM_ENT = 24,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [IDX_W-1:0]          idx,
  input  logic                      hi,
  input  logic [WORD_W-1:0]         wdata,
  output logic [NUM_ENT*ENT_W-1:0]  tbl_flat,
  output logic [WORD_W-1:0]         rd_half
);
  localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << MASK_BIT;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic [ENT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= ENT_RST;
      end else if (we && idx == IDX_W'(g)) begin
        if (hi) q[ENT_W-1:WORD_W] <= wdata;
        else    q[WORD_W-1:0]     <= wdata;
      end
    end
    assign tbl_flat[g*ENT_W +: ENT_W] = q;
  end

  always_comb begin
    rd_half = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (idx == IDX_W'(i)) begin
        rd_half = hi ? tbl_flat[i*ENT_W+WORD_W +: WORD_W]
                     : tbl_flat[i*ENT_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/intc_regwin.sv
module intc_regwin
  import intc_regwin_pkg::*;
#(
  parameter int NUM_ENT = 24,
  parameter int ADDR_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_valid,
  input  logic                     acc_write,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [31:0]              acc_wdata,
  output logic [31:0]              rd_data,
  output logic                     rd_valid,
  output logic                     acc_err,
  output logic [3:0]               unit_id,
  output logic [31:0]              arb_word,
  output logic [NUM_ENT*64-1:0]    tbl_flat,
  output logic [NUM_ENT-1:0]       ent_mask,
  output logic [NUM_ENT-1:0]       ent_level
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam logic [31:0] VER_WORD = (32'(NUM_ENT - 1) << 16) | 32'(VER_CODE);

  logic [WORD_W-1:0] sel_q;
  logic [3:0]        id_q;
  logic [WORD_W-1:0] arb_q;
  tgt_e              tgt;
  logic [IDX_W-1:0]  idx;
  logic              hi;
  logic [WORD_W-1:0] tbl_half;
  logic [7:0]        off;
  logic              hit_sel, hit_win, wr, rd, tbl_we;
  logic [WORD_W-1:0] rd_next;
  logic              err_next;

  intc_regwin_decode #(.NUM_ENT(NUM_ENT)) u_dec (
    .sel(sel_q), .tgt(tgt), .idx(idx), .hi(hi)
  );

  assign off     = acc_addr[7:0];
  assign hit_sel = (off == OFF_SEL);
  assign hit_win = (off == OFF_WIN);
  assign wr      = acc_valid && acc_write;
  assign rd      = acc_valid && !acc_write;
  assign tbl_we  = wr && hit_win && (tgt == TGT_TBL);

  intc_regwin_bank #(.NUM_ENT(NUM_ENT)) u_bank (
    .clk(clk), .rst(rst), .we(tbl_we), .idx(idx), .hi(hi),
    .wdata(acc_wdata), .tbl_flat(tbl_flat), .rd_half(tbl_half)
  );

  always_comb begin
    rd_next  = '0;
    err_next = 1'b0;
    if (hit_sel) begin
      rd_next = sel_q;
    end else if (hit_win) begin
      case (tgt)
        TGT_ID, TGT_ARB: rd_next = {4'h0, id_q, 24'h0};
        TGT_VER:         rd_next = VER_WORD;
        TGT_TBL:         rd_next = tbl_half;
        default:         err_next = 1'b1;
      endcase
    end else begin
      err_next = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      id_q     <= '0;
      arb_q    <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      acc_err  <= 1'b0;
    end else begin
      rd_valid <= rd;
      acc_err  <= acc_valid && err_next;
      if (rd) rd_data <= rd_next;
      if (wr && hit_sel) sel_q <= acc_wdata;
      if (wr && hit_win && tgt == TGT_ID)  id_q  <= acc_wdata[27:24];
      if (wr && hit_win && tgt == TGT_ARB) arb_q <= acc_wdata;
    end
  end

  assign unit_id  = id_q;
  assign arb_word = arb_q;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_fld
    assign ent_mask[g]  = tbl_flat[g*ENT_W + MASK_BIT];
    assign ent_level[g] = tbl_flat[g*ENT_W + LEVEL_BIT];
  end
endmodule

// File: rtl/intc_regwin_checker.sv
module intc_regwin_checker #(
  parameter int NUM_ENT = 24,
  parameter int ADDR_W  = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  acc_valid,
  input logic                  acc_write,
  input logic [ADDR_W-1:0]     acc_addr,
  input logic [31:0]           rd_data,
  input logic                  rd_valid,
  input logic                  acc_err,
  input logic [3:0]            unit_id,
  input logic [31:0]           arb_word,
  input logic [NUM_ENT*64-1:0] tbl_flat
);
  assert_read_answers_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> rd_valid);
  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && !acc_write) |=> !rd_valid);
  assert_err_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && acc_err) |-> (rd_data == 32'h0));
  assert_id_only_by_write_R4: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && acc_write) |=> $stable(unit_id));
  assert_arb_only_by_write_R6: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && acc_write) |=> $stable(arb_word));
  assert_tbl_only_by_write_R7: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && acc_write) |=> $stable(tbl_flat));
  assert_bad_offset_err_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_addr[7:0] != 8'h00 && acc_addr[7:0] != 8'h10) |=> acc_err);
endmodule

bind intc_regwin intc_regwin_checker #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .rd_data(rd_data), .rd_valid(rd_valid), .acc_err(acc_err),
  .unit_id(unit_id), .arb_word(arb_word), .tbl_flat(tbl_flat)
);

// File: tb/intc_regwin_tb.sv
module intc_regwin_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NENT = 24;
  localparam int AW = 12;

  logic clk = 0, rst = 1;
  logic acc_valid = 0, acc_write = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic rd_valid, acc_err;
  logic [3:0] unit_id;
  logic [31:0] arb_word;
  logic [NENT*64-1:0] tbl_flat;
  logic [NENT-1:0] ent_mask, ent_level;

  int total = 0, bad = 0;

  logic [31:0] m_sel, m_arb;
  logic [3:0]  m_id;
  logic [63:0] m_tbl [NENT];

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_regwin #(.NUM_ENT(NENT), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .acc_err(acc_err), .unit_id(unit_id),
    .arb_word(arb_word), .tbl_flat(tbl_flat), .ent_mask(ent_mask),
    .ent_level(ent_level)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sel = 0; m_arb = 0; m_id = 0;
    for (int i = 0; i < NENT; i++) m_tbl[i] = 64'h1_0000;
  endtask

  task automatic check_state();
    chk("R4", "unit_id", 64'(unit_id), 64'(m_id));
    chk("R6", "arb_word", 64'(arb_word), 64'(m_arb));
    for (int i = 0; i < NENT; i++) begin
      chk("R7", "entry", tbl_flat[i*64 +: 64], m_tbl[i]);
      chk("R10", "mask bit", 64'(ent_mask[i]), 64'(m_tbl[i][16]));
      chk("R10", "level bit", 64'(ent_level[i]), 64'(m_tbl[i][15]));
    end
  endtask

  task automatic acc(input bit w, input logic [AW-1:0] a, input logic [31:0] d,
                     input string req);
    logic [31:0] exp_d;
    bit exp_e;
    int idx;
    @(negedge clk);
    check_state();
    acc_valid = 1; acc_write = w; acc_addr = a; acc_wdata = d;
    exp_d = 0; exp_e = 0;
    if (a[7:0] == 8'h00) begin
      exp_d = m_sel;
      if (w) m_sel = d;
    end else if (a[7:0] == 8'h10) begin
      if (m_sel == 0 || m_sel == 2) begin
        exp_d = {4'h0, m_id, 24'h0};
        if (w && m_sel == 0) m_id = d[27:24];
        if (w && m_sel == 2) m_arb = d;
      end else if (m_sel == 1) begin
        exp_d = (32'(NENT - 1) << 16) | 32'h11;
      end else if (m_sel >= 32'h10 && m_sel < 32'h10 + 32'(2*NENT)) begin
        idx = int'((m_sel - 32'h10) >> 1);
        if (m_sel[0]) begin
          exp_d = m_tbl[idx][63:32];
          if (w) m_tbl[idx][63:32] = d;
        end else begin
          exp_d = m_tbl[idx][31:0];
          if (w) m_tbl[idx][31:0] = d;
        end
      end else exp_e = 1;
    end else exp_e = 1;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    chk(req, "rd_valid", 64'(rd_valid), 64'(!w));
    chk(req, "acc_err", 64'(acc_err), 64'(exp_e));
    if (!w) chk(req, "rd_data", 64'(rd_data), 64'(exp_d));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    acc(0, 12'h000, 0, "R1");
    acc(1, 12'h000, 32'h10, "R1");
    acc(0, 12'h010, 0, "R1");
    // R2 select location and aliasing
    acc(1, 12'h000, 32'hCAFE_0123, "R2");
    acc(0, 12'h100, 0, "R2");
    acc(1, 12'h300, 32'h0, "R2");
    acc(0, 12'h000, 0, "R2");
    // R4 identifier
    acc(1, 12'h010, 32'hA5FF_FFFF, "R4");
    acc(0, 12'h010, 0, "R4");
    // R5 version, write ignored
    acc(1, 12'h000, 32'h1, "R5");
    acc(0, 12'h010, 0, "R5");
    acc(1, 12'h010, 32'hFFFF_FFFF, "R5");
    acc(0, 12'h010, 0, "R5");
    // R6 arbitration word
    acc(1, 12'h000, 32'h2, "R6");
    acc(1, 12'h010, 32'hDEAD_BEEF, "R6");
    acc(0, 12'h010, 0, "R6");
    // R7 halves of first and last entries
    acc(1, 12'h000, 32'h10, "R7");
    acc(1, 12'h110, 32'h0000_80AB, "R7");
    acc(1, 12'h000, 32'h11, "R7");
    acc(1, 12'h010, 32'h7F00_0000, "R7");
    acc(0, 12'h010, 0, "R7");
    acc(1, 12'h000, 32'h10, "R7");
    acc(0, 12'h010, 0, "R7");
    acc(1, 12'h000, 32'h10 + 32'(2*NENT - 1), "R7");
    acc(1, 12'h010, 32'h1234_5678, "R7");
    acc(0, 12'h010, 0, "R7");
    // R8 out-of-range and gap selects
    acc(1, 12'h000, 32'h10 + 32'(2*NENT), "R8");
    acc(0, 12'h010, 0, "R8");
    acc(1, 12'h010, 32'hFFFF_FFFF, "R8");
    acc(1, 12'h000, 32'h5, "R8");
    acc(0, 12'h010, 0, "R8");
    acc(1, 12'h010, 32'hFFFF_FFFF, "R8");
    acc(1, 12'h000, 32'hF, "R8");
    acc(1, 12'h010, 32'h1, "R8");
    // R3 bad offsets leave state alone
    acc(1, 12'h000, 32'h12, "R3");
    acc(0, 12'h004, 0, "R3");
    acc(1, 12'h014, 32'hFFFF_FFFF, "R3");
    acc(1, 12'h0F0, 32'hFFFF_FFFF, "R3");
    acc(0, 12'h000, 0, "R3");
    // R10 and R7 sweep every entry
    for (int i = 0; i < NENT; i++) begin
      acc(1, 12'h000, 32'h10 + 32'(2*i), "R10");
      acc(1, 12'h010, (i % 2) ? 32'h0000_8031 : 32'h0001_0042 + 32'(i), "R10");
      acc(1, 12'h000, 32'h11 + 32'(2*i), "R7");
      acc(1, 12'h010, {8'(i), 24'h0}, "R7");
      acc(0, 12'h010, 0, "R7");
    end
    for (int i = 0; i < NENT; i++) begin
      acc(1, 12'h000, 32'h10 + 32'(2*i), "R7");
      acc(0, 12'h010, 0, "R7");
    end
    // R9 back-to-back idle gap keeps rd_valid low
    @(negedge clk);
    chk("R9", "idle rd_valid", 64'(rd_valid), 64'(0));
    // R1 reset again restores mask bits
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    acc(0, 12'h000, 0, "R1");
    @(negedge clk);
    check_state();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule